// File: doc/BRIEF.md
# Unit-Interval Calibration Sequencer

This block measures the transmit unit interval against a reference time-of-day. It requests a snapshot and gets back a 48-bit timestamp and a 15-bit reference counter. It then waits a fixed number of system clock cycles and takes a second snapshot. From the two snapshots it derives the elapsed time and the elapsed count. Each difference has its own wrap rule. It checks both values against a window of limits, and a failed check sends it back along a retry path that depends on the kind of failure. When both checks pass, it divides and writes the interval as a 4.28 fixed-point nanosecond value on a single-cycle write strobe.

After each successful write the sequencer keeps running. The latest snapshot becomes the reference for the next measurement, so every later result needs only one new snapshot. This tracks slow drift of the local clock. The timestamp is in units of 2^-16 ns, and a second of timestamp time is 48'h3B9A_CA00_0000. The enable input starts the sequence. Dropping the enable parks the sequencer.

Top module: `ui_cal_seq`

## Requirements
- R1: A snapshot is requested by holding `snap_req` high until a one-cycle `snap_ack`. In the response, `snap_lo` carries timestamp bits 31:0, `snap_hi[15:0]` carries timestamp bits 47:32, `snap_hi[30:16]` carries the count, and `snap_hi[31]` is the valid flag.
- R2: A first snapshot with the valid flag at 0 is dropped and requested again at once, with no change to the status outputs.
- R3: After a valid first snapshot is accepted, `snap_req` stays low for exactly `WAIT_CYCLES` cycles and then rises for the second snapshot.
- R4: If the second timestamp is less than or equal to the first, elapsed time is second + 48'h3B9A_CA00_0000 - first. Otherwise it is second - first.
- R5: If the second count is below the first, elapsed count is second + 2^15 - first. Otherwise it is second - first.
- R6: Any of the following raises `res_err` and restarts from a new first snapshot: a second snapshot with valid 0, an elapsed count of 0, elapsed time above `TIME_MAX`, or elapsed count above `CNT_MAX`.
- R7: Otherwise, elapsed time below `TIME_MIN` or elapsed count below `CNT_MIN` raises `res_err`. The first snapshot is then kept, and only the wait and the second snapshot are repeated. Values equal to a limit pass.
- R8: An accepted pair produces one single-cycle `wr_en` with `wr_data` = floor(time x LANES x 2^12 / (count x REF_CNT)). This is the interval in 4 integer and 28 fractional nanosecond bits. `busy` is high during the division and low on the write cycle.
- R9: After a write, the second snapshot becomes the first of the next measurement. The sequencer waits `WAIT_CYCLES` and requests only a new second snapshot.
- R10: After reset, and one cycle after `en` goes low, the sequencer is idle: no request, no write, not busy. A new `en` starts over from a first snapshot.
- R11: `res_ok` and `res_err` are never high together. Both are 0 after reset, and they hold the last outcome until the next outcome, including while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low parks the sequencer |
| snap_req | output | 1 | Snapshot request, held until acknowledged |
| snap_ack | input | 1 | One-cycle snapshot response strobe |
| snap_lo | input | 32 | Timestamp bits 31:0 |
| snap_hi | input | 32 | {valid, count[14:0], timestamp[47:32]} |
| wr_en | output | 1 | One-cycle write strobe for the result |
| wr_data | output | 32 | Interval in 4.28 fixed-point nanoseconds |
| busy | output | 1 | Divider running |
| res_ok | output | 1 | Last outcome was a written result |
| res_err | output | 1 | Last outcome was a rejected measurement |

## Verification
If the sequencer keeps the wrong reference snapshot, the next write carries a different interval value. That value is visible as soon as the division ends, about 64 cycles after the deciding snapshot. If the sequencer picks the wrong retry path, it pairs a later snapshot with the wrong partner, so the first written value is wrong, or no write ever arrives and the wait for a write runs out. A corrupted wait counter shows directly as the number of low cycles on `snap_req` between the two requests.

// File: rtl/ui_cal_seq.sv
`timescale 1ns/1ps
module ui_cal_seq #(
  parameter int          WAIT_CYCLES = 24,
  parameter int          LANES       = 4,
  parameter int          REF_CNT     = 8,
  parameter logic [47:0] TIME_MIN    = 48'h0000_0064_0000,
  parameter logic [47:0] TIME_MAX    = 48'h0001_0000_0000,
  parameter logic [14:0] CNT_MIN     = 15'd10,
  parameter logic [14:0] CNT_MAX     = 15'd20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  output logic        snap_req,
  input  logic        snap_ack,
  input  logic [31:0] snap_lo,
  input  logic [31:0] snap_hi,
  output logic        wr_en,
  output logic [31:0] wr_data,
  output logic        busy,
  output logic        res_ok,
  output logic        res_err
);
  localparam logic [48:0] WRAP = 49'h3B9A_CA00_0000;
  localparam int LW    = $clog2(LANES + 1);
  localparam int RW    = $clog2(REF_CNT + 1);
  localparam int NUM_W = 49 + LW + 12;
  localparam int DEN_W = 16 + RW;
  localparam int WCW   = $clog2(WAIT_CYCLES + 1);
  localparam int DCW   = $clog2(NUM_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ1, S_WAIT, S_REQ2, S_CHK, S_DIV, S_WR} st_t;
  st_t st;

  logic [47:0]      t0, t1;
  logic [14:0]      c0, c1;
  logic             v1;
  logic [WCW-1:0]   wcnt;
  logic [NUM_W-1:0] quo;
  logic [DEN_W-1:0] rem, den;
  logic [DCW-1:0]   dcnt;

  wire [47:0] s_time = {snap_hi[15:0], snap_lo};
  wire [14:0] s_cnt  = snap_hi[30:16];
  wire        s_val  = snap_hi[31];

  wire [48:0] dt = (t1 <= t0) ? ({1'b0, t1} + WRAP - {1'b0, t0}) : {1'b0, t1 - t0};
  wire [15:0] dc = (c1 < c0) ? ({1'b0, c1} + 16'd32768 - {1'b0, c0}) : {1'b0, c1 - c0};

  wire too_big   = !v1 || (dc == 16'd0) || (dt > {1'b0, TIME_MAX}) || (dc > {1'b0, CNT_MAX});
  wire too_small = (dt < {1'b0, TIME_MIN}) || (dc < {1'b0, CNT_MIN});

  wire [NUM_W-1:0] num   = (NUM_W'(dt) * NUM_W'(LANES)) << 12;
  wire [DEN_W-1:0] den_w = DEN_W'(dc) * DEN_W'(REF_CNT);

  wire [DEN_W:0] sh   = {rem, quo[NUM_W-1]};
  wire [DEN_W:0] diff = sh - {1'b0, den};

  assign snap_req = (st == S_REQ1) || (st == S_REQ2);
  assign busy     = (st == S_DIV);
  assign wr_en    = (st == S_WR);
  assign wr_data  = quo[31:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      t0      <= '0;
      t1      <= '0;
      c0      <= '0;
      c1      <= '0;
      v1      <= 1'b0;
      wcnt    <= '0;
      quo     <= '0;
      rem     <= '0;
      den     <= '0;
      dcnt    <= '0;
      res_ok  <= 1'b0;
      res_err <= 1'b0;
    end else if (!en) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_IDLE: st <= S_REQ1;
        S_REQ1:
          if (snap_ack && s_val) begin
            t0   <= s_time;
            c0   <= s_cnt;
            wcnt <= '0;
            st   <= S_WAIT;
          end
        S_WAIT:
          if (wcnt == WCW'(WAIT_CYCLES - 1)) st <= S_REQ2;
          else wcnt <= wcnt + 1'b1;
        S_REQ2:
          if (snap_ack) begin
            t1 <= s_time;
            c1 <= s_cnt;
            v1 <= s_val;
            st <= S_CHK;
          end
        S_CHK:
          if (too_big) begin
            res_err <= 1'b1;
            res_ok  <= 1'b0;
            st      <= S_REQ1;
          end else if (too_small) begin
            res_err <= 1'b1;
            res_ok  <= 1'b0;
            wcnt    <= '0;
            st      <= S_WAIT;
          end else begin
            quo  <= num;
            rem  <= '0;
            den  <= den_w;
            dcnt <= '0;
            st   <= S_DIV;
          end
        S_DIV: begin
          if (!diff[DEN_W]) begin
            rem <= diff[DEN_W-1:0];
            quo <= {quo[NUM_W-2:0], 1'b1};
          end else begin
            rem <= sh[DEN_W-1:0];
            quo <= {quo[NUM_W-2:0], 1'b0};
          end
          dcnt <= dcnt + 1'b1;
          if (dcnt == DCW'(NUM_W - 1)) st <= S_WR;
        end
        S_WR: begin
          res_ok  <= 1'b1;
          res_err <= 1'b0;
          t0      <= t1;
          c0      <= c1;
          wcnt    <= '0;
          st      <= S_WAIT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ui_cal_seq_chk.sv
`timescale 1ns/1ps
module ui_cal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic snap_req,
  input logic wr_en,
  input logic busy,
  input logic res_ok,
  input logic res_err
);
  // R8
  div_ends_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> wr_en);

  // R8
  write_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R1
  req_not_during_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |-> (!wr_en && !busy));

  // R11
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_ok, res_err}));

  // R9
  ok_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_ok) |-> $past(wr_en));

  // R10
  disable_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!snap_req && !busy && !wr_en));
endmodule

bind ui_cal_seq ui_cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .snap_req(snap_req),
  .wr_en(wr_en), .busy(busy), .res_ok(res_ok), .res_err(res_err)
);

// File: tb/test_ui_cal_seq.sv
`timescale 1ns/1ps
module test_ui_cal_seq;
  localparam int NWAIT = 24;
  localparam int NL    = 4;
  localparam int NR    = 8;
  localparam int NS    = 13;
  localparam longint unsigned WRAPV = 64'h3B9A_CA00_0000;

  function automatic longint unsigned ns(input longint unsigned x);
    return x << 16;
  endfunction

  function automatic logic [63:0] rs(input logic v, input int c, input longint unsigned t);
    return {v, c[14:0], t[47:0]};
  endfunction

  // per scenario: four responses served in order
  localparam logic [63:0] RSP [0:4*NS-1] = '{
    rs(1,100,ns(5000)),          rs(1,1100,ns(15000)),  64'd0, 64'd0,
    rs(1,32700,ns(2000)),        rs(1,500,ns(5000)),    64'd0, 64'd0,
    rs(1,10,WRAPV-ns(2000)),     rs(1,400,ns(1000)),    64'd0, 64'd0,
    rs(0,5,ns(100)),             rs(1,200,ns(1000)),    rs(1,1200,ns(9000)),  64'd0,
    rs(1,0,ns(1000)),            rs(0,500,ns(4000)),    rs(1,700,ns(20000)),  rs(1,2700,ns(30000)),
    rs(1,100,ns(1000)),          rs(1,200,ns(1050)),    rs(1,900,ns(8000)),   64'd0,
    rs(1,100,ns(1000)),          rs(1,105,ns(3000)),    rs(1,600,ns(6000)),   64'd0,
    rs(1,0,ns(1000)),            rs(1,500,ns(80000)),   rs(1,1000,ns(90000)), rs(1,1400,ns(95000)),
    rs(1,0,ns(1000)),            rs(1,25000,ns(5000)),  rs(1,100,ns(10000)),  rs(1,600,ns(14000)),
    rs(1,300,ns(1000)),          rs(1,300,ns(5000)),    rs(1,800,ns(9000)),   rs(1,1300,ns(13000)),
    rs(1,100,ns(5000)),          rs(1,600,ns(5000)),    rs(1,0,ns(2000)),     rs(1,900,ns(11000)),
    rs(1,50,ns(1000)),           rs(1,60,ns(1100)),     64'd0, 64'd0,
    rs(1,0,ns(1000)),            rs(1,20000,ns(66536)), 64'd0, 64'd0
  };
  // {error expected, index of first of pair, index of second of pair}
  localparam logic [4:0] META [0:NS-1] = '{
    {1'b0,2'd0,2'd1}, {1'b0,2'd0,2'd1}, {1'b0,2'd0,2'd1}, {1'b0,2'd1,2'd2},
    {1'b1,2'd2,2'd3}, {1'b1,2'd0,2'd2}, {1'b1,2'd0,2'd2}, {1'b1,2'd2,2'd3},
    {1'b1,2'd2,2'd3}, {1'b1,2'd2,2'd3}, {1'b1,2'd2,2'd3}, {1'b0,2'd0,2'd1},
    {1'b0,2'd0,2'd1}
  };
  string TAGS [0:NS-1] = '{"R8","R5","R4","R2","R6","R7","R7","R6","R6","R6","R6","R7","R6"};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, snap_ack = 1'b0;
  logic [31:0] snap_lo = '0, snap_hi = '0;
  logic snap_req, wr_en, busy, res_ok, res_err;
  logic [31:0] wr_data;

  int total = 0, bad = 0;
  int wr_total = 0, err_cyc = 0, busy_cyc = 0;
  logic [31:0] wr_log [0:255];

  always #4 clk = ~clk;

  ui_cal_seq #(.WAIT_CYCLES(NWAIT), .LANES(NL), .REF_CNT(NR)) i_ui_cal_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .snap_req(snap_req), .snap_ack(snap_ack),
    .snap_lo(snap_lo), .snap_hi(snap_hi), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .res_ok(res_ok), .res_err(res_err));

  always @(negedge clk) begin
    if (wr_en) begin
      wr_log[wr_total & 255] = wr_data;
      wr_total++;
    end
    if (res_err) err_cyc++;
    if (busy) busy_cyc++;
  end

  function automatic longint unsigned ui_exp(input logic [63:0] a, input logic [63:0] b);
    longint unsigned ta = a[47:0], tb = b[47:0], ca = a[62:48], cb = b[62:48], dt, dc;
    dt = (tb <= ta) ? tb + WRAPV - ta : tb - ta;
    dc = (cb < ca) ? cb + 32768 - ca : cb - ca;
    return ((dt * NL) << 12) / (dc * NR);
  endfunction

  task automatic chk(input bit ok, input string rq, input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic serve(input logic [63:0] r);
    int g = 0;
    while (!snap_req && g < 4000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
    chk(snap_req === 1'b1, "R1 request held", snap_req, 1);
    snap_lo  = r[31:0];
    snap_hi  = {r[63], r[62:48], r[47:32]};
    snap_ack = 1'b1;
    @(negedge clk);
    snap_ack = 1'b0;
    snap_lo  = '0;
    snap_hi  = '0;
  endtask

  task automatic wait_wr(input int base, output bit got);
    int g = 0;
    while (wr_total == base && g < 3000) begin @(posedge clk); g++; end
    got = (wr_total != base);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wb, eb, bb, n;
    bit got;
    longint unsigned e;
    logic [63:0] p0, p1, p2;

    repeat (4) @(negedge clk);
    // R10 reset state
    chk({snap_req, wr_en, busy} == 3'b000, "R10 reset outputs", {snap_req, wr_en, busy}, 0);
    chk({res_ok, res_err} == 2'b00, "R11 reset status", {res_ok, res_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!snap_req, "R10 idle without enable", snap_req, 0);

    for (int s = 0; s < NS; s++) begin
      en = 1'b0;
      repeat (3) @(negedge clk);
      wb = wr_total;
      eb = err_cyc;
      en = 1'b1;
      for (int k = 0; k <= int'(META[s][1:0]); k++) serve(RSP[4*s+k]);
      wait_wr(wb, got);
      chk(got, {"R8 write seen ", TAGS[s]}, got, 1);
      e = ui_exp(RSP[4*s+int'(META[s][3:2])], RSP[4*s+int'(META[s][1:0])]);
      chk(wr_log[wb & 255] == e[31:0], {"R8 value ", TAGS[s]}, wr_log[wb & 255], e);
      chk(res_ok && !res_err, "R11 ok after write", {res_ok, res_err}, 2'b10);
      chk((err_cyc > eb) == META[s][4], {"error report ", TAGS[s]}, err_cyc > eb, META[s][4]);
    end

    // R3 wait length, R8 busy, R9 reuse of the second snapshot
    p0 = rs(1, 100, ns(5000));
    p1 = rs(1, 1100, ns(15000));
    p2 = rs(1, 1900, ns(23000));
    en = 1'b0;
    repeat (3) @(negedge clk);
    wb = wr_total;
    bb = busy_cyc;
    en = 1'b1;
    serve(p0);
    n = 0;
    while (!snap_req && n < 1000) begin n++; @(negedge clk); end
    chk(n == NWAIT, "R3 wait cycles", n, NWAIT);
    serve(p1);
    wait_wr(wb, got);
    e = ui_exp(p0, p1);
    chk(got && wr_log[wb & 255] == e[31:0], "R8 directed value", wr_log[wb & 255], e);
    chk(busy_cyc > bb && !busy, "R8 busy before write", busy_cyc - bb, 1);
    serve(p2);
    wait_wr(wb + 1, got);
    e = ui_exp(p1, p2);
    chk(got && wr_log[(wb + 1) & 255] == e[31:0], "R9 reused first", wr_log[(wb + 1) & 255], e);

    // R10 enable drop while a request is pending, R11 sticky status
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    serve(rs(1, 100, ns(5000)));
    n = 0;
    while (!snap_req && n < 1000) begin n++; @(negedge clk); end
    en = 1'b0;
    @(negedge clk);
    chk(!snap_req && !busy, "R10 parked after disable", snap_req, 0);
    n = 0;
    repeat (40) begin @(negedge clk); if (snap_req) n++; end
    chk(n == 0, "R10 no request while disabled", n, 0);
    chk(res_ok && !res_err, "R11 status held while disabled", {res_ok, res_err}, 2'b10);
    wb = wr_total;
    p0 = rs(1, 0, ns(2000));
    p1 = rs(1, 500, ns(6000));
    en = 1'b1;
    serve(p0);
    serve(p1);
    wait_wr(wb, got);
    e = ui_exp(p0, p1);
    chk(got && wr_log[wb & 255] == e[31:0], "R10 restart from first", wr_log[wb & 255], e);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule